// File: doc/BRIEF.md
# Pipelined Multiply-Accumulator with Run-Time Operand Signedness

This block multiplies two operands and folds each product into a running sum. The sum either gains or loses the product, depending on a direction control. A load control starts a new sum. While a load is active the old sum is ignored, so the accumulator takes the product when adding and the negated product when subtracting. Each operand can be read as unsigned or as two's complement, chosen separately for each operand on every cycle. Any of these controls can instead be tied to a fixed value by parameter.

The data path has three stages: an optional input register, an optional product register, and an accumulator register that is always present. The controls travel through a two-stage pipeline next to the data, so a control value stays with the operands presented in the same cycle. The sign selects steer the multiplier one stage after entry. Direction, load and the sign selects together steer the accumulator one stage later. A clock enable stalls every stage. A synchronous active-low reset clears every register. The registered operands are also brought out, so a neighbouring unit can receive the operands.

Top module: `mac_accum_unit`

## Requirements
- R1: With direction control `add_sub` high the product is added to the sum; with it low the product is subtracted.
- R2: With `load` high the previous sum is ignored. The result becomes the product when adding, or zero minus the product when subtracting.
- R3: `sgn_a` high makes operand A two's complement and low makes it unsigned; `sgn_b` does the same for operand B independently. The product is sign-extended to the result width when either select is high, otherwise zero-extended.
- R4: When `USE_ADD_PORT` is 0 the `add_sub` input has no effect. The direction then comes from `ACC_SUB`: 0 means add, and 0 is the default.
- R5: When a sign-select port is disabled by parameter, that input has no effect. The operand then uses its `REP_*_SGN` parameter: 0 means unsigned, and 0 is the default.
- R6: `overflow` is re-evaluated every cycle and is not sticky. In signed mode it is high when the true signed sum falls outside `W_RES` bits. In unsigned mode it is high on a carry out of an add or a borrow from a subtract.
- R7: With all optional registers present, the result reflects an input three rising edges after it is applied. With all optional registers bypassed, this takes one edge. In both cases the controls stay aligned with their operands.
- R8: While `ce` is low no register changes, so `result`, `overflow`, `scan_a` and `scan_b` hold.
- R9: A rising edge with `rst_n` low clears every register, including the control pipeline: `result`, `overflow`, `scan_a` and `scan_b` read zero.
- R10: `scan_a` and `scan_b` show the operands as captured by the input registers, at their own widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable for every stage |
| a_in | input | W_A | Operand A |
| b_in | input | W_B | Operand B |
| sgn_a | input | 1 | Operand A is two's complement when high |
| sgn_b | input | 1 | Operand B is two's complement when high |
| add_sub | input | 1 | High adds the product, low subtracts it |
| load | input | 1 | Start a new sum from this product |
| result | output | W_RES | Accumulated sum |
| overflow | output | 1 | Overflow of the latest accumulation step |
| scan_a | output | W_A | Registered operand A |
| scan_b | output | W_B | Registered operand B |

## Verification
The hardest cases to reach are the accumulator edges in each signedness mode: a signed sum crossing the positive limit, an unsigned add carrying out, and a load while subtracting that borrows from zero. In each case a controlled value must already sit in the accumulator when the critical product arrives three stages later. A table of back-to-back operations first loads large products, then adds or subtracts again on the next cycle. The results of earlier rows set up the edge conditions for later ones, and the pipeline stays full throughout. Separate instances with tied-off controls and bypassed registers cover the static modes and the short latency.

// File: rtl/mac_pkg.sv
// Package: shared control bundle for the multiply-accumulator.
// Bit 0 is the direction, so a 4-bit vector maps directly onto the struct.
package mac_pkg;

    localparam int CTRL_W = 4;

    typedef struct packed {
        logic sgn_b;  // operand B two's complement
        logic sgn_a;  // operand A two's complement
        logic load;   // discard previous sum
        logic add;    // 1 add product, 0 subtract
    } mac_ctrl_t;

endpackage

// File: rtl/mac_pipe_reg.sv
// Optional pipeline register.
// EN=1: a register with a clock enable and a synchronous active-low reset.
// EN=0: a plain wire.
// Assumes the clock enable and the reset are shared by all stages.
module mac_pipe_reg #(
    parameter int W  = 1,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (EN) begin : g_reg
            logic [W-1:0] r;

            // Capture d when enabled, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= '0;
                else if (ce) r <= d;
            end

            assign q = r;

            // R8: a stalled stage keeps its value
            assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !ce |=> $stable(r));

            // R9: reset empties the stage
            assert_reset_R9: assert property (@(posedge clk)
                !rst_n |=> (r == '0));
        end else begin : g_wire
            logic unused_bypass;
            assign unused_bypass = ^{clk, rst_n, ce};
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mac_ctrl_pipe.sv
// Control pipeline for the multiply-accumulator.
// First, each control is replaced by its static parameter value when its port is
// disabled. Then every control passes through two optional stages.
// Stage one is meant to match the operand input registers.
// Stage two is meant to match the product register.
// Each mask has one bit per control: bit 0 direction, 1 load, 2 sign A, 3 sign B.
module mac_ctrl_pipe #(
    parameter bit       USE_ADD_PORT   = 1'b1,
    parameter bit       ACC_SUB        = 1'b0,
    parameter bit       USE_SGN_A_PORT = 1'b1,
    parameter bit       REP_A_SGN      = 1'b0,
    parameter bit       USE_SGN_B_PORT = 1'b1,
    parameter bit       REP_B_SGN      = 1'b0,
    parameter bit [3:0] STG1_MASK      = 4'hF,
    parameter bit [3:0] STG2_MASK      = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              add_sub,
    input  logic              load,
    input  logic              sgn_a,
    input  logic              sgn_b,
    output mac_pkg::mac_ctrl_t ctrl_mid,
    output mac_pkg::mac_ctrl_t ctrl_late
);

    localparam int N = mac_pkg::CTRL_W;

    mac_pkg::mac_ctrl_t c0;
    logic [N-1:0] v0, v1, v2;
    logic unused_ports;

    // Substitute the static settings for the disabled ports.
    always_comb begin
        c0.add   = USE_ADD_PORT   ? add_sub : ~ACC_SUB;
        c0.load  = load;
        c0.sgn_a = USE_SGN_A_PORT ? sgn_a   : REP_A_SGN;
        c0.sgn_b = USE_SGN_B_PORT ? sgn_b   : REP_B_SGN;
    end

    assign unused_ports = ^{add_sub, sgn_a, sgn_b};
    assign v0 = c0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            mac_pipe_reg #(.W(1), .EN(STG1_MASK[i])) u_first (
                .clk(clk), .rst_n(rst_n), .ce(ce), .d(v0[i]), .q(v1[i]));
            mac_pipe_reg #(.W(1), .EN(STG2_MASK[i])) u_second (
                .clk(clk), .rst_n(rst_n), .ce(ce), .d(v1[i]), .q(v2[i]));
        end
    endgenerate

    assign ctrl_mid  = v1;
    assign ctrl_late = v2;

endmodule

// File: rtl/mac_mult.sv
// Combinational multiplier. Each operand's signedness is chosen at run time.
// Each operand gets an extra top bit: a copy of its sign bit when it is signed,
// zero when unsigned. The two are then multiplied as signed values.
// The W_A+W_B low bits of the product hold every exact result.
module mac_mult #(
    parameter int W_A = 16,
    parameter int W_B = 16,
    localparam int W_P = W_A + W_B
) (
    input  logic [W_A-1:0] a,
    input  logic [W_B-1:0] b,
    input  logic           sa,
    input  logic           sb,
    output logic [W_P-1:0] prod
);

    logic signed [W_A:0]   a_x;
    logic signed [W_B:0]   b_x;
    logic signed [W_P+1:0] full;
    logic unused_hi;

    // Widen each operand according to its sign select, then multiply.
    always_comb begin
        a_x  = {sa & a[W_A-1], a};
        b_x  = {sb & b[W_B-1], b};
        full = (W_P+2)'(a_x) * (W_P+2)'(b_x);
    end

    assign prod      = full[W_P-1:0];
    assign unused_hi = ^full[W_P+1:W_P];

    // R3: with both operands unsigned, the result is the plain unsigned product
    always_comb begin
        if (!sa && !sb) begin
            assert_unsigned_R3: assert (prod == W_P'(a) * W_P'(b));
        end
    end

endmodule

// File: rtl/mac_accum.sv
// Accumulator stage with the result and overflow registers.
// The product is extended by the effective signedness: signed if either operand is.
// The sum is formed one bit wider than the result, so the top bits reveal
// signed overflow, an unsigned carry out, or an unsigned borrow.
// Assumes W_RES >= W_P.
module mac_accum #(
    parameter int W_P   = 32,
    parameter int W_RES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [W_P-1:0]   prod,
    input  logic             sgn,
    input  logic             add,
    input  logic             load,
    output logic [W_RES-1:0] result,
    output logic             overflow
);

    localparam int W_S = W_RES + 1;

    logic signed [W_P:0]   p_s;
    logic signed [W_S-1:0] p_w, fb_w, sum;
    logic                  ovf_n;
    logic [W_RES-1:0]      acc;
    logic                  ovf_q;

    // Extend the product and the feedback, then add or subtract.
    always_comb begin
        p_s   = {sgn & prod[W_P-1], prod};
        p_w   = W_S'(p_s);
        fb_w  = load ? '0 : {sgn & acc[W_RES-1], acc};
        sum   = add ? (fb_w + p_w) : (fb_w - p_w);
        ovf_n = sgn ? (sum[W_S-1] ^ sum[W_S-2]) : sum[W_S-1];
    end

    // Store the new sum and its overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            ovf_q <= 1'b0;
        end else if (ce) begin
            acc   <= sum[W_RES-1:0];
            ovf_q <= ovf_n;
        end
    end

    assign result   = acc;
    assign overflow = ovf_q;

    // R2: a load while adding leaves exactly the extended product
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && load && add) |=> (result == $past(p_w[W_RES-1:0])));

    // R6: an unsigned load-add cannot carry out
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && load && add && !sgn) |=> !overflow);

endmodule

// File: rtl/mac_accum_unit.sv
// Top of the multiply-accumulator.
// Data path: optional operand registers, then the multiplier, then the optional
// product register, then the accumulator.
// Controls travel through mac_ctrl_pipe. Its stage masks should match
// IN_REG_A/IN_REG_B (stage one) and MUL_REG (stage two), or the controls lose
// alignment with their data.
module mac_accum_unit #(
    parameter int       W_A            = 16,
    parameter int       W_B            = 16,
    parameter int       W_RES          = 40,
    parameter bit       IN_REG_A       = 1'b1,
    parameter bit       IN_REG_B       = 1'b1,
    parameter bit       MUL_REG        = 1'b1,
    parameter bit [3:0] CTRL_STG1_MASK = 4'hF,
    parameter bit [3:0] CTRL_STG2_MASK = 4'hF,
    parameter bit       USE_ADD_PORT   = 1'b1,
    parameter bit       ACC_SUB        = 1'b0,
    parameter bit       USE_SGN_A_PORT = 1'b1,
    parameter bit       REP_A_SGN      = 1'b0,
    parameter bit       USE_SGN_B_PORT = 1'b1,
    parameter bit       REP_B_SGN      = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [W_A-1:0]   a_in,
    input  logic [W_B-1:0]   b_in,
    input  logic             sgn_a,
    input  logic             sgn_b,
    input  logic             add_sub,
    input  logic             load,
    output logic [W_RES-1:0] result,
    output logic             overflow,
    output logic [W_A-1:0]   scan_a,
    output logic [W_B-1:0]   scan_b
);

    localparam int W_P = W_A + W_B;

    logic [W_A-1:0] a_q;
    logic [W_B-1:0] b_q;
    logic [W_P-1:0] prod, prod_q;
    mac_pkg::mac_ctrl_t ctrl_mid, ctrl_late;

    // Operand input registers.
    mac_pipe_reg #(.W(W_A), .EN(IN_REG_A)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .ce(ce), .d(a_in), .q(a_q));
    mac_pipe_reg #(.W(W_B), .EN(IN_REG_B)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .ce(ce), .d(b_in), .q(b_q));

    // Control pipeline kept in step with the data.
    mac_ctrl_pipe #(
        .USE_ADD_PORT(USE_ADD_PORT), .ACC_SUB(ACC_SUB),
        .USE_SGN_A_PORT(USE_SGN_A_PORT), .REP_A_SGN(REP_A_SGN),
        .USE_SGN_B_PORT(USE_SGN_B_PORT), .REP_B_SGN(REP_B_SGN),
        .STG1_MASK(CTRL_STG1_MASK), .STG2_MASK(CTRL_STG2_MASK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .add_sub(add_sub), .load(load), .sgn_a(sgn_a), .sgn_b(sgn_b),
        .ctrl_mid(ctrl_mid), .ctrl_late(ctrl_late));

    // Multiplier, steered by the stage-one sign selects.
    mac_mult #(.W_A(W_A), .W_B(W_B)) u_mult (
        .a(a_q), .b(b_q), .sa(ctrl_mid.sgn_a), .sb(ctrl_mid.sgn_b), .prod(prod));

    // Product register.
    mac_pipe_reg #(.W(W_P), .EN(MUL_REG)) u_reg_p (
        .clk(clk), .rst_n(rst_n), .ce(ce), .d(prod), .q(prod_q));

    // Accumulator, steered by the stage-two controls.
    mac_accum #(.W_P(W_P), .W_RES(W_RES)) u_acc (
        .clk(clk), .rst_n(rst_n), .ce(ce), .prod(prod_q),
        .sgn(ctrl_late.sgn_a | ctrl_late.sgn_b),
        .add(ctrl_late.add), .load(ctrl_late.load),
        .result(result), .overflow(overflow));

    assign scan_a = a_q;
    assign scan_b = b_q;

    generate
        if (IN_REG_A && IN_REG_B) begin : g_scan_chk
            // R10: scan outputs show the operands captured one edge earlier
            assert_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
                ce |=> (scan_a == $past(a_in) && scan_b == $past(b_in)));
        end
    endgenerate

endmodule

// File: tb/test_mac_accum_unit.sv
module test_mac_accum_unit;

    localparam int N_VEC = 13;

    // Vector layout: a[36:29] b[28:21] {sgn_a,sgn_b,add_sub,load}[20:17] result[16:1] ovf[0]
    localparam logic [36:0] VEC [N_VEC] = '{
        {8'h03, 8'h04, 4'b0011, 16'h000C, 1'b0},  // R2 R1 unsigned load-add
        {8'h05, 8'h06, 4'b0010, 16'h002A, 1'b0},  // R1 add
        {8'h02, 8'h07, 4'b0000, 16'h001C, 1'b0},  // R1 subtract
        {8'hFF, 8'h03, 4'b1010, 16'h0019, 1'b0},  // R3 signed A x unsigned B
        {8'hFE, 8'hFD, 4'b1110, 16'h001F, 1'b0},  // R3 both signed
        {8'hFF, 8'h02, 4'b0101, 16'hFE02, 1'b0},  // R2 R3 load-subtract, B signed
        {8'h0A, 8'h0A, 4'b0011, 16'h0064, 1'b0},  // R2 load-add
        {8'h0A, 8'h0A, 4'b0001, 16'hFF9C, 1'b1},  // R6 unsigned borrow on load-subtract
        {8'hFF, 8'hFF, 4'b0011, 16'hFE01, 1'b0},  // R6 not sticky
        {8'hFF, 8'hFF, 4'b0010, 16'hFC02, 1'b1},  // R6 unsigned carry
        {8'h80, 8'h80, 4'b1111, 16'h4000, 1'b0},  // R3 signed load
        {8'h80, 8'h80, 4'b1110, 16'h8000, 1'b1},  // R6 signed overflow
        {8'h7F, 8'h80, 4'b1101, 16'h3F80, 1'b0}   // R2 signed load-subtract
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic sgn_a = 1'b0, sgn_b = 1'b0, add_sub = 1'b1, load = 1'b0;

    logic [15:0] res_m, res_f, res_x;
    logic ovf_m, ovf_f, ovf_x;
    logic [7:0] sa_m, sb_m, sa_f, sb_f, sa_x, sb_x;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mac_accum_unit #(.W_A(8), .W_B(8), .W_RES(16)) i_mac_accum_unit (
        .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
        .sgn_a(sgn_a), .sgn_b(sgn_b), .add_sub(add_sub), .load(load),
        .result(res_m), .overflow(ovf_m), .scan_a(sa_m), .scan_b(sb_m));

    // Static subtract, both operands fixed signed; direction and sign ports ignored.
    mac_accum_unit #(.W_A(8), .W_B(8), .W_RES(16),
        .USE_ADD_PORT(1'b0), .ACC_SUB(1'b1),
        .USE_SGN_A_PORT(1'b0), .REP_A_SGN(1'b1),
        .USE_SGN_B_PORT(1'b0), .REP_B_SGN(1'b1)) i_mac_accum_unit_fix (
        .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
        .sgn_a(sgn_a), .sgn_b(sgn_b), .add_sub(add_sub), .load(load),
        .result(res_f), .overflow(ovf_f), .scan_a(sa_f), .scan_b(sb_f));

    // All optional registers bypassed, static controls at their defaults.
    mac_accum_unit #(.W_A(8), .W_B(8), .W_RES(16),
        .IN_REG_A(1'b0), .IN_REG_B(1'b0), .MUL_REG(1'b0),
        .CTRL_STG1_MASK(4'h0), .CTRL_STG2_MASK(4'h0),
        .USE_ADD_PORT(1'b0), .USE_SGN_A_PORT(1'b0), .USE_SGN_B_PORT(1'b0))
        i_mac_accum_unit_flat (
        .clk(clk), .rst_n(rst_n), .ce(ce), .a_in(a_in), .b_in(b_in),
        .sgn_a(sgn_a), .sgn_b(sgn_b), .add_sub(add_sub), .load(load),
        .result(res_x), .overflow(ovf_x), .scan_a(sa_x), .scan_b(sb_x));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [3:0] c);
        a_in = a; b_in = b;
        {sgn_a, sgn_b, add_sub, load} = c;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] hold_r;
        logic [7:0]  hold_a;
        @(negedge clk);
        tick(); tick();
        // R9: reset state
        check("R9 result after reset", 32'(res_m), 32'h0);
        check("R9 overflow after reset", 32'(ovf_m), 32'h0);
        check("R9 scan after reset", {16'h0, sa_m, sb_m}, 32'h0);
        rst_n = 1'b1;

        // Table walk, back to back, result checked three edges after entry (R7 alignment)
        for (int c = 0; c < N_VEC + 3; c++) begin
            if (c >= 3) begin
                check($sformatf("R1/R2/R3/R6 row %0d result", c - 3),
                      32'(res_m), 32'(VEC[c-3][16:1]));
                check($sformatf("R6 row %0d overflow", c - 3),
                      32'(ovf_m), 32'(VEC[c-3][0]));
            end
            if (c < N_VEC) drive(VEC[c][36:29], VEC[c][28:21], VEC[c][20:17]);
            else           drive(8'h00, 8'h00, 4'b0010);
            tick();
        end

        // R10: scan outputs follow the input registers
        drive(8'h5A, 8'hA5, 4'b0010);
        tick();
        check("R10 scan_a", 32'(sa_m), 32'h5A);
        check("R10 scan_b", 32'(sb_m), 32'hA5);

        // R7: three-edge latency from a fresh load
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        drive(8'h03, 8'h05, 4'b0011);
        tick();
        drive(8'h00, 8'h00, 4'b0010);
        tick();
        check("R7 result not yet after two edges", 32'(res_m), 32'h0);
        tick();
        check("R7 result after three edges", 32'(res_m), 32'd15);

        // R8: clock enable low freezes everything
        hold_r = res_m; hold_a = sa_m;
        ce = 1'b0;
        drive(8'h09, 8'h09, 4'b0011);
        tick(); tick(); tick(); tick();
        check("R8 result frozen", 32'(res_m), 32'(hold_r));
        check("R8 scan frozen", 32'(sa_m), 32'(hold_a));
        drive(8'h00, 8'h00, 4'b0010);
        ce = 1'b1;
        tick(); tick(); tick();
        check("R8 frozen load never taken", 32'(res_m), 32'd15);

        // R9: reset in mid-run clears result and operands
        drive(8'h44, 8'h22, 4'b0011);
        tick();
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check("R9 mid-run result", 32'(res_m), 32'h0);
        check("R9 mid-run scan", {16'h0, sa_m, sb_m}, 32'h0);
        drive(8'h00, 8'h00, 4'b0010);
        tick(); tick(); tick();
        check("R9 control pipeline flushed", 32'(res_m), 32'h0);

        // R4 R5: static subtract and signed operands; ports ask for add/unsigned
        drive(8'hFE, 8'h03, 4'b0011);
        tick();
        drive(8'h01, 8'h01, 4'b0010);
        tick(); tick();
        check("R4 R5 static load-subtract of -6", 32'(res_f), 32'd6);
        drive(8'h00, 8'h00, 4'b0010);
        tick();
        check("R4 static subtract", 32'(res_f), 32'd5);

        // R7 R4 R5: bypassed variant, defaults add and unsigned; ports ask otherwise
        drive(8'hFF, 8'h02, 4'b1101);
        tick();
        check("R7 R5 one-edge latency, unsigned default", 32'(res_x), 32'd510);
        drive(8'h01, 8'h01, 4'b1100);
        tick();
        check("R4 default add", 32'(res_x), 32'd511);
        check("R6 bypassed no overflow", 32'(ovf_x), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule